// File: doc/BRIEF.md
# Pixel Configuration Serial Load Chain

This block holds the per-pixel configuration of a pixel-array sensor and loads it over one serial input. A staging register with one bit per pixel column is filled one bit at a time. A column-push command then moves the staging word one place down every column at once. Each column is a shift chain that holds the configuration words of all its pixels. Each pixel word is five bits: a mask bit and a four-bit comparator trim, which gives sixteen trim levels. The settings of every pixel are presented on parallel outputs. A masked pixel forces its hit output low.

The bits pushed out of the far end of the columns are caught, in parallel, by a capture register, which can then be unloaded serially through one output. A full configuration takes rows-per-column times five pushes. The readback therefore returns the settings that were loaded before the current ones. To verify a load, the array is loaded a second time and the first data is checked as it comes out.

Column count and rows per column are parameters. The pixel word layout is fixed by a shared packed type.

Top module: `pix_cfg_chain`

## Requirements
- R1: A synchronous active-high reset clears the staging register, the capture register and all pixel storage. After reset every pixel reads mask 0 and trim 0, and ser_out is 0.
- R2: Each cycle with ser_clk_en high shifts ser_in into staging bit 0, and every older staging bit moves up one index. After NCOLS strobes, the first bit sent sits at index NCOLS-1, which feeds column NCOLS-1.
- R3: A column push moves each column chain one position down, and staging bit c enters position 0 of column c. The push leaves the staging register unchanged.
- R4: Pixel r of column c is chain positions r*5 to r*5+4 of that column. Position r*5 is the mask, and positions r*5+1 to r*5+4 are the trim, least significant first. The flat pixel index is c*NROWS+r, and the trim of pixel p is pix_trim[p*4+:4].
- R5: On every column push, the capture register loads, in parallel, the bit leaving the last position of each column. The bit from column c goes to capture bit c.
- R6: ser_out is capture bit NCOLS-1. Each cycle with cap_shift_en high and no column push moves the capture bits up one index, with 0 entering at bit 0. A column push in the same cycle wins over the unload shift.
- R7: During a second full load, the word unloaded after push k is the staging word written at push k of the first load, with column NCOLS-1 first.
- R8: A col_shift that arrives while ser_clk_en is high is held off. It is carried out in the first cycle with ser_clk_en low, and it uses the staging register including the bit shifted in that cycle.
- R9: hit_out of a pixel is low when its mask is 1, and otherwise equals its hit_in.
- R10: Without a column push, ser_clk_en and cap_shift_en strobes leave every pixel's mask and trim unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial configuration data |
| ser_clk_en | input | 1 | Shift ser_in into the staging register |
| col_shift | input | 1 | Push the staging word into the columns |
| cap_shift_en | input | 1 | Unload one capture bit toward ser_out |
| ser_out | output | 1 | Serial readback data |
| hit_in | input | NCOLS*NROWS | Raw pixel hits |
| hit_out | output | NCOLS*NROWS | Hits after masking |
| pix_mask | output | NCOLS*NROWS | Mask bit of each pixel |
| pix_trim | output | NCOLS*NROWS*4 | Trim field of each pixel |

## Verification
The bench targets the deferred column push. A push issued together with the last serial bit must use the staging word that includes that bit. A design that pushed in the same cycle would load the stale bit 0, and a design that dropped the push would load nothing. It checks the two-load readback word by word. This catches a capture that takes the wrong chain end or reverses the unload order, which would return the current data or mirrored words. It also checks that a push wins over an unload in the same cycle, that pixel fields are unpacked with the mask in the low position, and that masking gates hits only on masked pixels.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int PIX_TRIM_W = 4;

    typedef struct packed {
        logic [PIX_TRIM_W-1:0] trim;
        logic                  mask;
    } pix_cfg_t;

    localparam int PIX_BITS = $bits(pix_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BIT   = 2'd1,
        ST_PUSH  = 2'd2
    } stage_op_e;

    function automatic pix_cfg_t slice_pixel(input logic [PIX_BITS-1:0] bits);
        pix_cfg_t p;
        p = pix_cfg_t'(bits);
        return p;
    endfunction

endpackage

// File: rtl/cfg_stage.sv
module cfg_stage
    import cfg_pkg::*;
#(
    parameter int NCOLS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             ser_clk_en,
    input  logic             col_shift,
    output logic [NCOLS-1:0] stage_q,
    output logic             col_go
);

    logic      pend_q;
    logic      want_push;
    stage_op_e op;

    assign want_push = col_shift | pend_q;

    always_comb begin
        if (ser_clk_en)
            op = ST_BIT;
        else if (want_push)
            op = ST_PUSH;
        else
            op = ST_IDLE;
    end

    assign col_go = (op == ST_PUSH);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (op == ST_BIT)
                stage_q <= {stage_q[NCOLS-2:0], ser_in};
            pend_q <= want_push & (op == ST_BIT);
        end
    end

endmodule

// File: rtl/cfg_column.sv
module cfg_column #(
    parameter int DEPTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             din,
    output logic [DEPTH-1:0] chain_q,
    output logic             dout
);

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else if (push)
            chain_q <= {chain_q[DEPTH-2:0], din};
    end

    assign dout = chain_q[DEPTH-1];

endmodule

// File: rtl/cfg_capture.sv
module cfg_capture #(
    parameter int NCOLS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NCOLS-1:0] par_in,
    input  logic             shift_en,
    output logic [NCOLS-1:0] cap_q,
    output logic             ser_out
);

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (load)
            cap_q <= par_in;
        else if (shift_en)
            cap_q <= {cap_q[NCOLS-2:0], 1'b0};
    end

    assign ser_out = cap_q[NCOLS-1];

endmodule

// File: rtl/pix_cfg_chain.sv
module pix_cfg_chain
    import cfg_pkg::*;
#(
    parameter int NCOLS = 8,
    parameter int NROWS = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ser_in,
    input  logic                              ser_clk_en,
    input  logic                              col_shift,
    input  logic                              cap_shift_en,
    output logic                              ser_out,
    input  logic [NCOLS*NROWS-1:0]            hit_in,
    output logic [NCOLS*NROWS-1:0]            hit_out,
    output logic [NCOLS*NROWS-1:0]            pix_mask,
    output logic [NCOLS*NROWS*PIX_TRIM_W-1:0] pix_trim
);

    localparam int DEPTH = NROWS * PIX_BITS;

    logic [NCOLS-1:0] stage_q;
    logic             col_go;
    logic [NCOLS-1:0] col_last;
    logic [NCOLS-1:0] cap_q;

    cfg_stage #(.NCOLS(NCOLS)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .ser_clk_en (ser_clk_en),
        .col_shift  (col_shift),
        .stage_q    (stage_q),
        .col_go     (col_go)
    );

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        logic [DEPTH-1:0] chain;

        cfg_column #(.DEPTH(DEPTH)) u_col (
            .clk     (clk),
            .rst     (rst),
            .push    (col_go),
            .din     (stage_q[c]),
            .chain_q (chain),
            .dout    (col_last[c])
        );

        for (genvar r = 0; r < NROWS; r++) begin : g_pix
            localparam int P = c*NROWS + r;
            pix_cfg_t cfg;
            assign cfg = slice_pixel(chain[r*PIX_BITS +: PIX_BITS]);
            assign pix_mask[P]                       = cfg.mask;
            assign pix_trim[P*PIX_TRIM_W +: PIX_TRIM_W] = cfg.trim;
            assign hit_out[P]                        = hit_in[P] & ~cfg.mask;
        end
    end

    cfg_capture #(.NCOLS(NCOLS)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .load     (col_go),
        .par_in   (col_last),
        .shift_en (cap_shift_en),
        .cap_q    (cap_q),
        .ser_out  (ser_out)
    );

endmodule

// File: rtl/pix_cfg_chain_chk.sv
module pix_cfg_chain_chk #(
    parameter int NCOLS = 8,
    parameter int NPIX  = 32,
    parameter int TW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_clk_en,
    input logic             col_shift,
    input logic             cap_shift_en,
    input logic             ser_out,
    input logic [NPIX-1:0]  hit_out,
    input logic [NPIX-1:0]  pix_mask,
    input logic [NPIX*TW-1:0] pix_trim,
    input logic             col_go,
    input logic [NCOLS-1:0] stage_q,
    input logic [NCOLS-1:0] cap_q,
    input logic [NCOLS-1:0] col_last
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pix_mask == '0 && pix_trim == '0 && cap_q == '0 && stage_q == '0));

    p_push_keeps_stage_r3: assert property (@(posedge clk) disable iff (rst)
        (col_go && !ser_clk_en) |=> $stable(stage_q));

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        col_go |=> (cap_q == $past(col_last)));

    p_unload_r6: assert property (@(posedge clk) disable iff (rst)
        (cap_shift_en && !col_go) |=> (cap_q == {$past(cap_q[NCOLS-2:0]), 1'b0}));

    p_defer_r8: assert property (@(posedge clk) disable iff (rst)
        (col_shift && ser_clk_en) ##1 !ser_clk_en |-> col_go);

    p_mask_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (hit_out & pix_mask) == '0);

    p_hold_storage_r10: assert property (@(posedge clk) disable iff (rst)
        !col_go |=> ($stable(pix_mask) && $stable(pix_trim)));

endmodule

bind pix_cfg_chain pix_cfg_chain_chk #(
    .NCOLS (NCOLS),
    .NPIX  (NCOLS*NROWS),
    .TW    (cfg_pkg::PIX_TRIM_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ser_clk_en   (ser_clk_en),
    .col_shift    (col_shift),
    .cap_shift_en (cap_shift_en),
    .ser_out      (ser_out),
    .hit_out      (hit_out),
    .pix_mask     (pix_mask),
    .pix_trim     (pix_trim),
    .col_go       (col_go),
    .stage_q      (stage_q),
    .cap_q        (cap_q),
    .col_last     (col_last)
);

// File: tb/pix_cfg_chain_tb.sv
module pix_cfg_chain_tb;

    localparam int NC    = 8;
    localparam int NR    = 4;
    localparam int NP    = NC*NR;
    localparam int DEPTH = NR*5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0, ser_clk_en = 1'b0, col_shift = 1'b0, cap_shift_en = 1'b0;
    logic ser_out;
    logic [NP-1:0]   hit_in = '0;
    logic [NP-1:0]   hit_out, pix_mask;
    logic [NP*4-1:0] pix_trim;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [DEPTH-1:0] model [NC];
    logic [NC-1:0]    word_a [DEPTH];

    always #4 clk = ~clk;

    pix_cfg_chain #(.NCOLS(NC), .NROWS(NR)) u_dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .ser_clk_en(ser_clk_en),
        .col_shift(col_shift), .cap_shift_en(cap_shift_en), .ser_out(ser_out),
        .hit_in(hit_in), .hit_out(hit_out), .pix_mask(pix_mask), .pix_trim(pix_trim)
    );

    // {hit_in, expected hit_out} with odd columns masked (mask = 32'hF0F0F0F0)
    localparam logic [63:0] HIT_VEC [6] = '{
        {32'hFFFF_FFFF, 32'h0F0F_0F0F},
        {32'h1234_5678, 32'h0204_0608},
        {32'hA5A5_A5A5, 32'h0505_0505},
        {32'h0000_0000, 32'h0000_0000},
        {32'hF0F0_F0F0, 32'h0000_0000},
        {32'h0F0F_0F0F, 32'h0F0F_0F0F}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int c = 0; c < NC; c++) model[c] = '0;
    endtask

    task automatic send_word(input logic [NC-1:0] w);
        for (int i = NC-1; i >= 0; i--) begin
            @(negedge clk); ser_in = w[i]; ser_clk_en = 1'b1;
        end
        @(negedge clk); ser_clk_en = 1'b0;
    endtask

    task automatic push(input logic [NC-1:0] w);
        col_shift = 1'b1;
        @(negedge clk); col_shift = 1'b0;
        for (int c = 0; c < NC; c++) model[c] = {model[c][DEPTH-2:0], w[c]};
    endtask

    task automatic compare_model(input string req);
        logic [NP-1:0]   em;
        logic [NP*4-1:0] et;
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NR; r++) begin
                em[c*NR+r]        = model[c][r*5];
                et[(c*NR+r)*4 +: 4] = model[c][r*5+1 +: 4];
            end
        check(req, {32'd0, pix_mask}, {32'd0, em});
        check(req, 64'(pix_trim), 64'(et));
    endtask

    task automatic unload(output logic [NC-1:0] w);
        for (int i = NC-1; i >= 0; i--) begin
            w[i] = ser_out;
            cap_shift_en = 1'b1;
            @(negedge clk);
        end
        cap_shift_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] rb;
        logic [NP*4-1:0] trim_snap;
        logic [NP-1:0]   mask_snap;
        do_reset();

        // R1: reset state
        check("R1", {32'd0, pix_mask}, 64'd0);
        check("R1", 64'(pix_trim), 64'd0);
        check("R1", {63'd0, ser_out}, 64'd0);

        // R2 R3: one word in, one push -> row 0 mask of column c = bit c
        send_word(8'b1011_0010);
        push(8'b1011_0010);
        for (int c = 0; c < NC; c++)
            check("R2", {63'd0, pix_mask[c*NR]}, {63'd0, 1'b1 & (8'b1011_0010 >> c)});
        // R3: staging unchanged by push; second push repeats the same word
        push(8'b1011_0010);
        compare_model("R3");

        // R4: full load A with distinct words
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            word_a[k] = 8'(k*37 + 5);
            send_word(word_a[k]);
            push(word_a[k]);
        end
        compare_model("R4");

        // R5 R6 R7: second load B, unload after each push returns word A_k
        for (int k = 0; k < DEPTH; k++) begin
            send_word(8'(k*91 + 3));
            push(8'(k*91 + 3));
            unload(rb);
            check("R7", 64'(rb), 64'(word_a[k]));
        end
        compare_model("R5");

        // R6: push and unload together -> capture wins, ser_out = column 7 leaving bit
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            send_word(8'h80);
            push(8'h80);
        end
        send_word(8'h00);
        col_shift = 1'b1; cap_shift_en = 1'b1;
        @(negedge clk); col_shift = 1'b0; cap_shift_en = 1'b0;
        for (int c = 0; c < NC; c++) model[c] = {model[c][DEPTH-2:0], 1'b0};
        check("R6", {63'd0, ser_out}, 64'd1);
        cap_shift_en = 1'b1; @(negedge clk); cap_shift_en = 1'b0;
        check("R6", {63'd0, ser_out}, 64'd0);

        // R8: col_shift with the last serial bit is deferred and uses that bit
        do_reset();
        for (int i = NC-1; i >= 1; i--) begin
            @(negedge clk); ser_in = i[0]; ser_clk_en = 1'b1;
        end
        @(negedge clk); ser_in = 1'b1; ser_clk_en = 1'b1; col_shift = 1'b1;
        @(negedge clk); ser_clk_en = 1'b0; col_shift = 1'b0;
        @(negedge clk);
        // word sent: bit i = i[0] for i>=1, bit0 = 1 -> 8'b1010_1011
        for (int c = 0; c < NC; c++)
            check("R8", {63'd0, pix_mask[c*NR]}, {63'd0, 1'b1 & (8'b1010_1011 >> c)});
        check("R8", {63'd0, pix_mask[1]}, 64'd0);

        // R9: odd columns fully masked
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            send_word(8'hAA);
            push(8'hAA);
        end
        foreach (HIT_VEC[i]) begin
            hit_in = HIT_VEC[i][63:32];
            @(negedge clk);
            check("R9", {32'd0, hit_out}, {32'd0, HIT_VEC[i][31:0]});
        end

        // R10: strobes without a push leave storage alone
        mask_snap = pix_mask; trim_snap = pix_trim;
        send_word(8'h5C);
        unload(rb);
        send_word(8'h33);
        check("R10", {32'd0, pix_mask}, {32'd0, mask_snap});
        check("R10", 64'(pix_trim), 64'(trim_snap));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule